// File: doc/BRIEF.md
# CRC-8 Guarded Register Access Engine

This block is the device-side integrity stage behind a byte-oriented serial target front end. The front end delivers frame boundaries and received bytes, and asks for bytes to send. The block tracks the position of each byte in the frame and drives a single write port into the register file. It also supplies the read address and turns the register file's read data into response bytes.

In protected mode every register transfer carries a check byte after its data byte. The check byte is an 8-bit CRC with polynomial 0x1D and initial value 0xFF. It covers three bytes in order: the 7-bit device address shifted left with the direction bit in bit 0, the register address, and the data byte. Incoming writes are committed only when the received check byte matches. Read responses get a freshly computed check byte. With protection off, each transfer is a single data byte. Register addresses above a configurable ceiling (0x82 by default) are never written, and reading them returns zero.

A read uses the register pointer left by the most recent write frame. A write frame that carries only a register address just sets the pointer, which is the usual way to select a register before a read frame.

Top module: `crcg_guard`

## Requirements
- R1: The check byte is CRC-8 with polynomial 0x1D and initial value 0xFF, fed MSB first with the bytes {dev_addr,rw}, register address, data. rw is 0 for writes and 1 for read responses.
- R2: In protected mode (crc_mode=1), a write frame carries register address, data and check byte. When the check byte matches, wr_en pulses for one cycle, in the cycle after the check byte is accepted, with wr_addr and wr_data set to the frame's register address and data.
- R3: In protected mode, a check byte that does not match produces no wr_en, and crc_err goes to 1 in the cycle after that byte. crc_err then stays at 1.
- R4: A pulse on err_clr drives crc_err to 0 on the next cycle. If a mismatch is detected in the same cycle as the clear, crc_err is set.
- R5: In plain mode (crc_mode=0), wr_en pulses in the cycle after the data byte. Any further bytes in the same frame are ignored.
- R6: A write to a register address above REG_MAX (default 0x82) never asserts wr_en, in either mode. A matching check byte on such a write does not set crc_err.
- R7: A write frame that ends (eof) before its last required byte has arrived leaves the register file untouched.
- R8: In protected mode, the first byte of a read frame is the register file content at the pointer. The second byte is the CRC with rw=1 over that data. Every later byte is 0xFF.
- R9: In plain mode, the first byte of a read frame is the register content and every later byte is 0xFF.
- R10: A read with the pointer above REG_MAX returns data 0x00. In protected mode it is followed by the CRC of 0x00.
- R11: The first byte of each write frame sets the pointer, and the pointer is kept across frames. After reset the pointer is 0, and wr_en, tx_vld and crc_err are 0.
- R12: tx_vld pulses in the cycle after a tx_rdy strobe made inside a read frame, and never otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| crc_mode | input | 1 | 1 selects protected transfers, 0 plain single-byte transfers |
| dev_addr | input | 7 | This device's 7-bit bus address |
| sof | input | 1 | Start-of-frame strobe after an address match |
| sof_rnw | input | 1 | Direction of the starting frame, 1 for read |
| eof | input | 1 | End-of-frame strobe (stop or repeated start) |
| rx_vld | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte |
| tx_rdy | input | 1 | Request for the next response byte |
| tx_vld | output | 1 | Response byte valid |
| tx_byte | output | 8 | Response byte |
| rd_addr | output | 8 | Register file read address (current pointer) |
| rd_data | input | 8 | Register file read data for rd_addr |
| wr_en | output | 1 | Register file write strobe |
| wr_addr | output | 8 | Register file write address |
| wr_data | output | 8 | Register file write data |
| err_clr | input | 1 | Clear strobe for the check error flag |
| crc_err | output | 1 | Sticky check-byte mismatch flag |

## Verification
The assertions assume that the front end issues sof, eof, rx_vld and tx_rdy as single-cycle strobes, at most one per cycle. They also assume that received bytes arrive only while a write frame is open. Under those conditions a commit is always separated from the next one by at least a register byte, and every response byte answers a request. Each bench task drives exactly one strobe for one cycle and returns it to zero, so the stimulus stays within these assumptions. The only intentional overlap is the clear-versus-set case, where err_clr and rx_vld are driven together.

// File: rtl/crcg_pkg.sv
package crcg_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_W  = 7;

  typedef enum logic [1:0] {
    WS_REG  = 2'd0,
    WS_DATA = 2'd1,
    WS_CRC  = 2'd2,
    WS_DONE = 2'd3
  } wstate_e;

  typedef enum logic [1:0] {
    RS_DATA = 2'd0,
    RS_CRC  = 2'd1,
    RS_PAD  = 2'd2
  } rstate_e;
endpackage

// File: rtl/crcg_crc8_step.sv
module crcg_crc8_step
  import crcg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] POLY = 8'h1D
) (
  input  logic [BYTE_W-1:0] crc_in,
  input  logic [BYTE_W-1:0] data_in,
  output logic [BYTE_W-1:0] crc_out
);
  // One full byte per evaluation: XOR in, then BYTE_W conditional shifts.
  logic [BYTE_W-1:0] stage [BYTE_W+1];

  assign stage[0] = crc_in ^ data_in;

  for (genvar g = 0; g < BYTE_W; g++) begin : g_shift
    assign stage[g+1] = stage[g][BYTE_W-1] ? ({stage[g][BYTE_W-2:0], 1'b0} ^ POLY)
                                           : {stage[g][BYTE_W-2:0], 1'b0};
  end

  assign crc_out = stage[BYTE_W];
endmodule

// File: rtl/crcg_wr_path.sv
module crcg_wr_path
  import crcg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REG_MAX  = 8'h82,
  parameter logic [BYTE_W-1:0] CRC_POLY = 8'h1D,
  parameter logic [BYTE_W-1:0] CRC_INIT = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_mode,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic              sof,
  input  logic              sof_rnw,
  input  logic              eof,
  input  logic              rx_vld,
  input  logic [BYTE_W-1:0] rx_byte,
  input  logic              err_clr,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_addr,
  output logic [BYTE_W-1:0] wr_data,
  output logic              crc_err
);
  logic              act_q,  act_d;
  wstate_e           st_q,   st_d;
  logic [BYTE_W-1:0] reg_q,  reg_d;
  logic [BYTE_W-1:0] dat_q,  dat_d;
  logic [BYTE_W-1:0] crc_q,  crc_d;
  logic [BYTE_W-1:0] ptr_q,  ptr_d;
  logic              we_q,   we_d;
  logic [BYTE_W-1:0] wa_q,   wa_d;
  logic [BYTE_W-1:0] wd_q,   wd_d;
  logic              err_q,  err_d;
  logic              err_set;
  logic [BYTE_W-1:0] hdr_crc, run_crc;
  logic              in_range;

  crcg_crc8_step #(.POLY(CRC_POLY)) u_hdr (
    .crc_in (CRC_INIT),
    .data_in({dev_addr, 1'b0}),
    .crc_out(hdr_crc)
  );

  crcg_crc8_step #(.POLY(CRC_POLY)) u_run (
    .crc_in (crc_q),
    .data_in(rx_byte),
    .crc_out(run_crc)
  );

  assign in_range = (reg_q <= REG_MAX);

  always_comb begin
    act_d   = act_q;
    st_d    = st_q;
    reg_d   = reg_q;
    dat_d   = dat_q;
    crc_d   = crc_q;
    ptr_d   = ptr_q;
    we_d    = 1'b0;
    wa_d    = wa_q;
    wd_d    = wd_q;
    err_set = 1'b0;
    if (sof) begin
      act_d = !sof_rnw;
      st_d  = WS_REG;
      crc_d = hdr_crc;
    end else if (eof) begin
      act_d = 1'b0;
    end else if (rx_vld && act_q) begin
      unique case (st_q)
        WS_REG: begin
          reg_d = rx_byte;
          ptr_d = rx_byte;
          crc_d = run_crc;
          st_d  = WS_DATA;
        end
        WS_DATA: begin
          dat_d = rx_byte;
          crc_d = run_crc;
          if (crc_mode) begin
            st_d = WS_CRC;
          end else begin
            st_d = WS_DONE;
            if (in_range) begin
              we_d = 1'b1;
              wa_d = reg_q;
              wd_d = rx_byte;
            end
          end
        end
        WS_CRC: begin
          st_d = WS_DONE;
          if (rx_byte == crc_q) begin
            if (in_range) begin
              we_d = 1'b1;
              wa_d = reg_q;
              wd_d = dat_q;
            end
          end else begin
            err_set = 1'b1;
          end
        end
        default: ;
      endcase
    end
    err_d = err_set | (err_q & ~err_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      st_q  <= WS_DONE;
      reg_q <= '0;
      dat_q <= '0;
      crc_q <= '0;
      ptr_q <= '0;
      we_q  <= 1'b0;
      wa_q  <= '0;
      wd_q  <= '0;
      err_q <= 1'b0;
    end else begin
      act_q <= act_d;
      st_q  <= st_d;
      reg_q <= reg_d;
      dat_q <= dat_d;
      crc_q <= crc_d;
      ptr_q <= ptr_d;
      we_q  <= we_d;
      wa_q  <= wa_d;
      wd_q  <= wd_d;
      err_q <= err_d;
    end
  end

  assign ptr     = ptr_q;
  assign wr_en   = we_q;
  assign wr_addr = wa_q;
  assign wr_data = wd_q;
  assign crc_err = err_q;
endmodule

// File: rtl/crcg_rd_path.sv
module crcg_rd_path
  import crcg_pkg::*;
#(
  parameter logic [BYTE_W-1:0] REG_MAX  = 8'h82,
  parameter logic [BYTE_W-1:0] CRC_POLY = 8'h1D,
  parameter logic [BYTE_W-1:0] CRC_INIT = 8'hFF,
  parameter logic [BYTE_W-1:0] PAD_BYTE = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              crc_mode,
  input  logic [DEV_W-1:0]  dev_addr,
  input  logic              sof,
  input  logic              sof_rnw,
  input  logic              eof,
  input  logic              tx_rdy,
  input  logic [BYTE_W-1:0] ptr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              tx_vld,
  output logic [BYTE_W-1:0] tx_byte
);
  logic              act_q,  act_d;
  rstate_e           st_q,   st_d;
  logic [BYTE_W-1:0] crc_q,  crc_d;
  logic              txv_q,  txv_d;
  logic [BYTE_W-1:0] txb_q,  txb_d;
  logic [BYTE_W-1:0] hdr0_crc, hdr1_crc, dat_crc;
  logic [BYTE_W-1:0] data_out;

  assign data_out = (ptr <= REG_MAX) ? rd_data : '0;

  // Device/direction byte and pointer byte are folded in when the frame opens.
  crcg_crc8_step #(.POLY(CRC_POLY)) u_hdr0 (
    .crc_in (CRC_INIT),
    .data_in({dev_addr, 1'b1}),
    .crc_out(hdr0_crc)
  );

  crcg_crc8_step #(.POLY(CRC_POLY)) u_hdr1 (
    .crc_in (hdr0_crc),
    .data_in(ptr),
    .crc_out(hdr1_crc)
  );

  crcg_crc8_step #(.POLY(CRC_POLY)) u_dat (
    .crc_in (crc_q),
    .data_in(data_out),
    .crc_out(dat_crc)
  );

  always_comb begin
    act_d = act_q;
    st_d  = st_q;
    crc_d = crc_q;
    txv_d = 1'b0;
    txb_d = txb_q;
    if (sof) begin
      act_d = sof_rnw;
      st_d  = RS_DATA;
      crc_d = hdr1_crc;
    end else if (eof) begin
      act_d = 1'b0;
    end else if (tx_rdy && act_q) begin
      txv_d = 1'b1;
      unique case (st_q)
        RS_DATA: begin
          txb_d = data_out;
          crc_d = dat_crc;
          st_d  = crc_mode ? RS_CRC : RS_PAD;
        end
        RS_CRC: begin
          txb_d = crc_q;
          st_d  = RS_PAD;
        end
        default: txb_d = PAD_BYTE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
      st_q  <= RS_PAD;
      crc_q <= '0;
      txv_q <= 1'b0;
      txb_q <= '0;
    end else begin
      act_q <= act_d;
      st_q  <= st_d;
      crc_q <= crc_d;
      txv_q <= txv_d;
      txb_q <= txb_d;
    end
  end

  assign tx_vld  = txv_q;
  assign tx_byte = txb_q;
endmodule

// File: rtl/crcg_guard.sv
module crcg_guard
  import crcg_pkg::*;
#(
  parameter logic [7:0] REG_MAX  = 8'h82,
  parameter logic [7:0] CRC_POLY = 8'h1D,
  parameter logic [7:0] CRC_INIT = 8'hFF,
  parameter logic [7:0] PAD_BYTE = 8'hFF
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       crc_mode,
  input  logic [6:0] dev_addr,
  input  logic       sof,
  input  logic       sof_rnw,
  input  logic       eof,
  input  logic       rx_vld,
  input  logic [7:0] rx_byte,
  input  logic       tx_rdy,
  output logic       tx_vld,
  output logic [7:0] tx_byte,
  output logic [7:0] rd_addr,
  input  logic [7:0] rd_data,
  output logic       wr_en,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  input  logic       err_clr,
  output logic       crc_err
);
  logic [BYTE_W-1:0] ptr;

  crcg_wr_path #(
    .REG_MAX (REG_MAX),
    .CRC_POLY(CRC_POLY),
    .CRC_INIT(CRC_INIT)
  ) u_wr (
    .clk     (clk),
    .rst_n   (rst_n),
    .crc_mode(crc_mode),
    .dev_addr(dev_addr),
    .sof     (sof),
    .sof_rnw (sof_rnw),
    .eof     (eof),
    .rx_vld  (rx_vld),
    .rx_byte (rx_byte),
    .err_clr (err_clr),
    .ptr     (ptr),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .crc_err (crc_err)
  );

  crcg_rd_path #(
    .REG_MAX (REG_MAX),
    .CRC_POLY(CRC_POLY),
    .CRC_INIT(CRC_INIT),
    .PAD_BYTE(PAD_BYTE)
  ) u_rd (
    .clk     (clk),
    .rst_n   (rst_n),
    .crc_mode(crc_mode),
    .dev_addr(dev_addr),
    .sof     (sof),
    .sof_rnw (sof_rnw),
    .eof     (eof),
    .tx_rdy  (tx_rdy),
    .ptr     (ptr),
    .rd_data (rd_data),
    .tx_vld  (tx_vld),
    .tx_byte (tx_byte)
  );

  assign rd_addr = ptr;
endmodule

// File: rtl/crcg_guard_chk.sv
module crcg_guard_chk #(
  parameter logic [7:0] REG_MAX = 8'h82
) (
  input logic       clk,
  input logic       rst_n,
  input logic       rx_vld,
  input logic       tx_rdy,
  input logic       tx_vld,
  input logic       wr_en,
  input logic [7:0] wr_addr,
  input logic       err_clr,
  input logic       crc_err
);
  // R6
  wr_addr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_addr <= REG_MAX));

  // R2
  wr_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5
  wr_after_byte_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> $past(rx_vld));

  // R3
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (crc_err && !err_clr) |=> crc_err);

  // R3
  err_no_commit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(crc_err) |-> (!wr_en && $past(rx_vld)));

  // R4
  err_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_clr && !rx_vld) |=> !crc_err);

  // R12
  tx_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_vld |-> $past(tx_rdy));
endmodule

bind crcg_guard crcg_guard_chk #(.REG_MAX(REG_MAX)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .rx_vld (rx_vld),
  .tx_rdy (tx_rdy),
  .tx_vld (tx_vld),
  .wr_en  (wr_en),
  .wr_addr(wr_addr),
  .err_clr(err_clr),
  .crc_err(crc_err)
);

// File: tb/tb_crcg_guard.sv
`timescale 1ns/1ps
module tb_crcg_guard;
  localparam logic [7:0] TOP_REG = 8'h82;

  logic       clk;
  logic       rst_n;
  logic       crc_mode;
  logic [6:0] dev_addr;
  logic       sof, sof_rnw, eof, rx_vld, tx_rdy, err_clr;
  logic [7:0] rx_byte;
  logic       tx_vld, wr_en, crc_err;
  logic [7:0] tx_byte, rd_addr, rd_data, wr_addr, wr_data;

  logic [7:0] mem     [256];
  logic [7:0] exp_mem [256];
  int n_chk;
  int n_bad;

  crcg_guard dut (
    .clk(clk), .rst_n(rst_n), .crc_mode(crc_mode), .dev_addr(dev_addr),
    .sof(sof), .sof_rnw(sof_rnw), .eof(eof), .rx_vld(rx_vld), .rx_byte(rx_byte),
    .tx_rdy(tx_rdy), .tx_vld(tx_vld), .tx_byte(tx_byte), .rd_addr(rd_addr),
    .rd_data(rd_data), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .err_clr(err_clr), .crc_err(crc_err)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Register file model driven only by the block's write port.
  always @(posedge clk) if (wr_en) mem[wr_addr] <= wr_data;
  assign rd_data = mem[rd_addr];

  // Bit-serial reference: 24 message bits, MSB first.
  function automatic logic [7:0] ref_crc(input logic [7:0] b0, input logic [7:0] b1,
                                         input logic [7:0] b2);
    logic [23:0] m;
    logic [7:0]  c;
    logic        fb;
    m = {b0, b1, b2};
    c = 8'hFF;
    for (int i = 23; i >= 0; i--) begin
      fb = c[7] ^ m[i];
      c  = {c[6:0], 1'b0};
      if (fb) c = c ^ 8'h1D;
    end
    return c;
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  endtask

  task automatic start_frame(input logic rnw);
    @(negedge clk); sof = 1'b1; sof_rnw = rnw;
    @(negedge clk); sof = 1'b0; sof_rnw = 1'b0;
  endtask

  task automatic end_frame();
    @(negedge clk); eof = 1'b1;
    @(negedge clk); eof = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input logic clr);
    @(negedge clk); rx_vld = 1'b1; rx_byte = b; err_clr = clr;
    @(negedge clk); rx_vld = 1'b0; err_clr = 1'b0;
  endtask

  task automatic get_byte(output logic [7:0] b, output logic v);
    @(negedge clk); tx_rdy = 1'b1;
    @(negedge clk); tx_rdy = 1'b0;
    b = tx_byte; v = tx_vld;
  endtask

  task automatic clear_err();
    @(negedge clk); err_clr = 1'b1;
    @(negedge clk); err_clr = 1'b0;
  endtask

  // Protected write; bad flips the check byte.
  task automatic wr_crc(input logic [7:0] a, input logic [7:0] d, input logic bad,
                        input logic clr);
    logic [7:0] c;
    logic       ok;
    c  = ref_crc({dev_addr, 1'b0}, a, d) ^ {7'd0, bad};
    ok = !bad && (a <= TOP_REG);
    start_frame(1'b0);
    send_byte(a, 1'b0);
    send_byte(d, 1'b0);
    chk("R2 no early commit", {7'd0, wr_en}, 8'd0);
    send_byte(c, clr);
    chk(bad ? "R3 wr_en" : ((a <= TOP_REG) ? "R2 wr_en" : "R6 wr_en"), {7'd0, wr_en}, {7'd0, ok});
    if (ok) begin
      chk("R2 wr_addr", wr_addr, a);
      chk("R2 wr_data", wr_data, d);
      exp_mem[a] = d;
    end
    end_frame();
  endtask

  task automatic wr_plain(input logic [7:0] a, input logic [7:0] d);
    start_frame(1'b0);
    send_byte(a, 1'b0);
    send_byte(d, 1'b0);
    chk((a <= TOP_REG) ? "R5 wr_en" : "R6 plain wr_en", {7'd0, wr_en}, {7'd0, a <= TOP_REG});
    if (a <= TOP_REG) begin
      chk("R5 wr_data", wr_data, d);
      exp_mem[a] = d;
    end
    send_byte(~d, 1'b0);
    chk("R5 extra byte ignored", {7'd0, wr_en}, 8'd0);
    end_frame();
  endtask

  task automatic set_ptr(input logic [7:0] a);
    start_frame(1'b0);
    send_byte(a, 1'b0);
    end_frame();
  endtask

  task automatic rd_check(input logic [7:0] a);
    logic [7:0] b, e;
    logic       v;
    e = (a <= TOP_REG) ? exp_mem[a] : 8'h00;
    set_ptr(a);
    start_frame(1'b1);
    get_byte(b, v);
    chk("R12 tx_vld", {7'd0, v}, 8'd1);
    chk((a <= TOP_REG) ? (crc_mode ? "R8 data" : "R9 data") : "R10 data", b, e);
    get_byte(b, v);
    if (crc_mode) chk((a <= TOP_REG) ? "R1 R8 crc" : "R10 crc", b, ref_crc({dev_addr, 1'b1}, a, e));
    else          chk("R9 pad", b, 8'hFF);
    if (crc_mode) begin
      get_byte(b, v);
      chk("R8 pad", b, 8'hFF);
    end
    end_frame();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [7:0] b;
    logic       v;
    n_chk = 0; n_bad = 0;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'h00; exp_mem[i] = 8'h00; end
    rst_n = 1'b0; crc_mode = 1'b1; dev_addr = 7'h29;
    sof = 0; sof_rnw = 0; eof = 0; rx_vld = 0; rx_byte = 0; tx_rdy = 0; err_clr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R11 reset wr_en", {7'd0, wr_en}, 8'd0);
    chk("R11 reset tx_vld", {7'd0, tx_vld}, 8'd0);
    chk("R11 reset crc_err", {7'd0, crc_err}, 8'd0);
    chk("R11 reset pointer", rd_addr, 8'd0);

    // R2 R6 R8 R10: protected sweep over and past the register range.
    for (int a = 0; a < 136; a++) wr_crc(a[7:0], 8'(a * 37 + 5), 1'b0, 1'b0);
    chk("R6 no error on good crc", {7'd0, crc_err}, 8'd0);
    for (int a = 0; a < 136; a++) rd_check(a[7:0]);
    dev_addr = 7'h7F;
    for (int a = 126; a < 136; a++) rd_check(a[7:0]);

    // R3 R4: mismatch, stickiness, clear, set over clear.
    wr_crc(8'h20, 8'hA5, 1'b1, 1'b0);
    chk("R3 crc_err set", {7'd0, crc_err}, 8'd1);
    rd_check(8'h20);
    wr_crc(8'h21, 8'h3C, 1'b0, 1'b0);
    chk("R3 crc_err sticky", {7'd0, crc_err}, 8'd1);
    clear_err();
    chk("R4 cleared", {7'd0, crc_err}, 8'd0);
    wr_crc(8'h22, 8'h11, 1'b1, 1'b1);
    chk("R4 set wins over clear", {7'd0, crc_err}, 8'd1);
    clear_err();
    chk("R4 cleared again", {7'd0, crc_err}, 8'd0);

    // R7: truncated frames.
    start_frame(1'b0);
    send_byte(8'h30, 1'b0);
    send_byte(8'h99, 1'b0);
    end_frame();
    chk("R7 no commit", {7'd0, wr_en}, 8'd0);
    rd_check(8'h30);

    // R5 R6 R9: plain sweep.
    crc_mode = 1'b0;
    dev_addr = 7'h08;
    for (int a = 0; a < 136; a++) wr_plain(a[7:0], 8'(a ^ 8'h5A));
    for (int a = 0; a < 136; a++) rd_check(a[7:0]);
    start_frame(1'b0);
    send_byte(8'h31, 1'b0);
    end_frame();
    chk("R7 plain no commit", {7'd0, wr_en}, 8'd0);

    // R11: pointer kept across read frames.
    set_ptr(8'h05);
    for (int k = 0; k < 2; k++) begin
      start_frame(1'b1);
      get_byte(b, v);
      chk("R11 pointer kept", b, exp_mem[5]);
      end_frame();
    end

    // R12: request outside a read frame.
    get_byte(b, v);
    chk("R12 no tx_vld outside frame", {7'd0, v}, 8'd0);
    @(negedge clk);
    chk("R12 tx_vld low", {7'd0, tx_vld}, 8'd0);

    finish_run();
  end
endmodule